// File: doc/BRIEF.md
# Configuration Integrity Monitor with Mismatch Reset

This block keeps the device's configuration words in a primary register bank and keeps a second, shadow bank that holds the bitwise inverse of every word. Every clock cycle, all word pairs are compared in parallel. A bit upset in either bank breaks the complement relation for that pair. The block then issues a one-cycle reset request to the reset tree and drives a sticky, active-low cause flag to 0.

The reset tree drives a load strobe for as long as a hard or power reset lasts. While the strobe is high, both banks take the nonvolatile image from the image port, and the shadow bank receives the inverted image in the same cycle. No request is raised during that window. A mismatch reset is one of the hard resets, so it also ends in a reload. This prevents a single upset from causing a reset loop.

Only a mismatch can clear the cause flag, and only a software write of 1 can set it again. Power-on initialises the flag to 1. Radiation or ESD upsets are modelled through a flip-mask input, which toggles stored bits in either bank.

Top module: `cfg_mismatch_monitor`

## Requirements
- R1: While por_n is low and just after it goes high, cfg_o is all zeros, flag_o is 1 and rst_req_o is 0.
- R2: A clock edge with load_i high stores image_i into cfg_o, so it is visible from the next cycle. Word k occupies bits k*WORD_W upward.
- R3: A clock edge with upset_i nonzero and load_i low XORs the stored bits. Bits [TOT-1:0] hit the primary bank (cfg_o). Bits [2*TOT-1:TOT] hit the shadow bank at the same word and bit positions. An edge that leaves any pair out of complement causes rst_req_o to be 1 in the cycle after the next edge. This holds for every word.
- R4: rst_req_o is high for exactly one cycle per mismatch event. It does not rise again until a load has taken place.
- R5: rst_req_o is never 1 in the cycle after an edge with load_i high. If load_i and upset_i are high on the same edge, the load wins and the upset is discarded.
- R6: flag_o goes to 0 on the same edge that raises rst_req_o, and it falls for no other reason.
- R7: An edge with flag_wr_i high and flag_wdata_i 1 sets flag_o to 1. A write of 0 has no effect.
- R8: A load does not change flag_o.
- R9: If a mismatch request and a write of 1 fall on the same edge, flag_o becomes 0.
- R10: A flip of the same bit in both banks keeps the pair in complement. It changes cfg_o and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| image_i | input | NUM_WORDS*WORD_W | Nonvolatile configuration image |
| load_i | input | 1 | Reload strobe from the reset tree |
| upset_i | input | 2*NUM_WORDS*WORD_W | Bit-flip mask: primary bank low half, shadow bank high half |
| flag_wr_i | input | 1 | Cause-flag write enable |
| flag_wdata_i | input | 1 | Cause-flag write data (only 1 takes effect) |
| flag_o | output | 1 | Sticky cause flag, 0 after a mismatch reset |
| rst_req_o | output | 1 | One-cycle reset request |
| cfg_o | output | NUM_WORDS*WORD_W | Current configuration words |

## Verification
The bench builds the block with NUM_WORDS=4 and WORD_W=8. With these values every word position, and both the lowest and the highest bit of a bank, can be upset one at a time in a short run. The 32-bit image can hold a distinct pattern per word, so a misplaced word slice shows up on cfg_o. The small width also allows a double flip in both banks and a same-edge load-versus-upset collision to be placed at exact cycles.

// File: rtl/cfg_mm_pkg.sv
package cfg_mm_pkg;
    typedef struct packed {
        logic req;
        logic fired;
        logic flag;
    } ctrl_st_t;

    localparam ctrl_st_t CTRL_RST = '{req: 1'b0, fired: 1'b0, flag: 1'b1};
endpackage

// File: rtl/cfg_mm_word.sv
module cfg_mm_word #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] image_i,
    input  logic [WORD_W-1:0] flip_cfg_i,
    input  logic [WORD_W-1:0] flip_shd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              mism_o
);
    typedef struct packed {
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] shd;
    } pair_t;

    pair_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cfg = image_i;
            st_d.shd = ~image_i;
        end else begin
            st_d.cfg = st_q.cfg ^ flip_cfg_i;
            st_d.shd = st_q.shd ^ flip_shd_i;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.cfg <= '0;
            st_q.shd <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.cfg;
    // a healthy pair XORs to all ones
    assign mism_o = |(~(st_q.cfg ^ st_q.shd));
endmodule

// File: rtl/cfg_mm_ctrl.sv
module cfg_mm_ctrl
    import cfg_mm_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic any_mism_i,
    input  logic load_i,
    input  logic flag_wr_i,
    input  logic flag_wdata_i,
    output logic req_o,
    output logic flag_o
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // request once per event, never inside the reload window
        st_d.req = any_mism_i && !load_i && !st_q.fired;
        if (load_i) begin
            st_d.fired = 1'b0;
        end else if (st_d.req) begin
            st_d.fired = 1'b1;
        end
        if (st_d.req) begin
            st_d.flag = 1'b0;
        end else if (flag_wr_i && flag_wdata_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o  = st_q.req;
    assign flag_o = st_q.flag;
endmodule

// File: rtl/cfg_mismatch_monitor.sv
module cfg_mismatch_monitor #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 8
) (
    input  logic                            clk,
    input  logic                            por_n,
    input  logic [NUM_WORDS*WORD_W-1:0]     image_i,
    input  logic                            load_i,
    input  logic [2*NUM_WORDS*WORD_W-1:0]   upset_i,
    input  logic                            flag_wr_i,
    input  logic                            flag_wdata_i,
    output logic                            flag_o,
    output logic                            rst_req_o,
    output logic [NUM_WORDS*WORD_W-1:0]     cfg_o
);
    localparam int TOT_W = NUM_WORDS * WORD_W;

    logic [NUM_WORDS-1:0] mism_vec;
    logic                 any_mism;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        cfg_mm_word #(.WORD_W(WORD_W)) u_word (
            .clk        (clk),
            .por_n      (por_n),
            .load_i     (load_i),
            .image_i    (image_i[w*WORD_W +: WORD_W]),
            .flip_cfg_i (upset_i[w*WORD_W +: WORD_W]),
            .flip_shd_i (upset_i[TOT_W + w*WORD_W +: WORD_W]),
            .word_o     (cfg_o[w*WORD_W +: WORD_W]),
            .mism_o     (mism_vec[w])
        );
    end

    assign any_mism = |mism_vec;

    cfg_mm_ctrl u_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .any_mism_i   (any_mism),
        .load_i       (load_i),
        .flag_wr_i    (flag_wr_i),
        .flag_wdata_i (flag_wdata_i),
        .req_o        (rst_req_o),
        .flag_o       (flag_o)
    );
endmodule

// File: rtl/cfg_mismatch_monitor_chk.sv
module cfg_mismatch_monitor_chk #(
    parameter int CFG_W = 32
) (
    input logic             clk,
    input logic             por_n,
    input logic [CFG_W-1:0] image_i,
    input logic             load_i,
    input logic             flag_wr_i,
    input logic             flag_wdata_i,
    input logic             flag_o,
    input logic             rst_req_o,
    input logic [CFG_W-1:0] cfg_o
);
    AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> (cfg_o == $past(image_i)));                       // R2
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |=> !rst_req_o);                                   // R4
    AST_NO_REQ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!por_n)
        load_i |=> !rst_req_o);                                      // R5
    AST_FLAG_LOW_WITH_REQ: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |-> !flag_o);                                      // R6
    AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $fell(flag_o) |-> rst_req_o);                                // R6
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flag_o) |-> $past(flag_wr_i && flag_wdata_i));         // R7
endmodule

bind cfg_mismatch_monitor cfg_mismatch_monitor_chk #(.CFG_W(NUM_WORDS*WORD_W)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .image_i      (image_i),
    .load_i       (load_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .flag_o       (flag_o),
    .rst_req_o    (rst_req_o),
    .cfg_o        (cfg_o)
);

// File: tb/cfg_mismatch_monitor_tb.sv
module cfg_mismatch_monitor_tb;
    localparam int NW = 4;
    localparam int WW = 8;
    localparam int TW = NW * WW;

    logic            clk = 1'b0;
    logic            por_n = 1'b0;
    logic [TW-1:0]   image = '0;
    logic            load = 1'b0;
    logic [2*TW-1:0] upset = '0;
    logic            fwr = 1'b0;
    logic            fwd = 1'b0;
    logic            flag;
    logic            req;
    logic [TW-1:0]   cfg;

    always #4 clk = ~clk;

    cfg_mismatch_monitor #(.NUM_WORDS(NW), .WORD_W(WW)) u_dut (
        .clk          (clk),
        .por_n        (por_n),
        .image_i      (image),
        .load_i       (load),
        .upset_i      (upset),
        .flag_wr_i    (fwr),
        .flag_wdata_i (fwd),
        .flag_o       (flag),
        .rst_req_o    (req),
        .cfg_o        (cfg)
    );

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic          req;
        logic          flag;
        logic [TW-1:0] cfg;
        string         tag;
    } exp_t;
    exp_t sbq[$];

    // reference state derived from the requirements
    logic [TW-1:0] m_cfg = '0;
    logic [TW-1:0] m_shd = '1;
    logic          m_fired = 1'b0;
    logic          m_flag = 1'b1;

    function automatic bit model_mism();
        for (int w = 0; w < NW; w++)
            if (m_cfg[w*WW +: WW] !== ~m_shd[w*WW +: WW]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [TW-1:0] act, input logic [TW-1:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic step(input logic ld, input logic [TW-1:0] img,
                        input logic [2*TW-1:0] up, input logic wr, input logic wd,
                        input string tag);
        exp_t e;
        logic rq;
        @(negedge clk);
        load = ld; image = img; upset = up; fwr = wr; fwd = wd;
        rq = model_mism() && !ld && !m_fired;
        m_fired = ld ? 1'b0 : (m_fired | rq);
        m_flag  = rq ? 1'b0 : ((wr && wd) ? 1'b1 : m_flag);
        if (ld) begin
            m_cfg = img; m_shd = ~img;
        end else begin
            m_cfg = m_cfg ^ up[TW-1:0]; m_shd = m_shd ^ up[2*TW-1:TW];
        end
        @(posedge clk);
        e.req = rq; e.flag = m_flag; e.cfg = m_cfg; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            chk(req === e.req, e.tag, "rst_req_o", TW'(req), TW'(e.req));
            chk(flag === e.flag, e.tag, "flag_o", TW'(flag), TW'(e.flag));
            chk(cfg === e.cfg, e.tag, "cfg_o", cfg, e.cfg);
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(cfg === '0, "R1", "cfg_o in reset", cfg, '0);
        chk(flag === 1'b1, "R1", "flag_o in reset", TW'(flag), TW'(1));
        chk(req === 1'b0, "R1", "rst_req_o in reset", TW'(req), TW'(0));
        por_n = 1'b1;
        idle(2, "R1");

        // R2 load and steady state
        step(1'b1, 32'hA5C3_0F96, '0, 1'b0, 1'b0, "R2");
        idle(3, "R2");

        // R3 single flips on every word, primary and shadow, low and high bit
        for (int w = 0; w < NW; w++) begin
            step(1'b0, '0, (2*TW)'(1) << (w*WW), 1'b0, 1'b0, "R3");
            idle(3, "R4");
            step(1'b1, 32'h1234_5678 + 32'(w), '0, 1'b0, 1'b0, "R8");
            step(1'b0, '0, '0, 1'b1, 1'b0, "R7");
            step(1'b0, '0, '0, 1'b1, 1'b1, "R7");
            step(1'b0, '0, (2*TW)'(1) << (TW + w*WW + WW - 1), 1'b0, 1'b0, "R3");
            idle(2, "R6");
            step(1'b1, 32'hFFFF_0000 ^ 32'(w), '0, 1'b1, 1'b1, "R8");
            idle(1, "R2");
        end

        // R5 load and upset on the same edge
        step(1'b1, 32'h0055_AA00, 64'h1, 1'b0, 1'b0, "R5");
        idle(2, "R5");
        // R5 mismatch pending, load arrives on the request edge
        step(1'b0, '0, 64'h0000_0100_0000_0000, 1'b0, 1'b0, "R5");
        step(1'b1, 32'hC0DE_0001, '0, 1'b0, 1'b0, "R5");
        idle(2, "R5");

        // R9 request and write of 1 on the same edge
        step(1'b0, '0, 64'h0000_0000_0000_0010, 1'b0, 1'b0, "R9");
        step(1'b0, '0, '0, 1'b1, 1'b1, "R9");
        idle(1, "R9");
        step(1'b1, 32'h7E7E_7E7E, '0, 1'b1, 1'b1, "R9");

        // R10 same bit flipped in both banks stays undetected
        step(1'b0, '0, {32'h0002_0000, 32'h0002_0000}, 1'b0, 1'b0, "R10");
        idle(3, "R10");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule